// File: doc/BRIEF.md
# Page Write Collector and Programming Timer

This block sits behind the serial front end of a small non-volatile memory. When a write header arrives (a word address, the half-select and the current protect mask), it opens a 16-byte row. Each data byte that follows is stored at the current column, and the column then advances. The column wraps within the row, so the row part of the address never changes. A bit per column records which bytes were loaded, so a partial page commits only those columns. A Stop with at least one loaded byte starts a self-timed programming window of fixed length, whether one byte or a full row was loaded.

During that window the block raises `busy_o`. It also walks the row once in ascending column order and issues one array write per loaded column. The front end uses `busy_o` to NACK any device address during acknowledge polling. While busy, the block ignores headers, bytes, Stop and abort.

A header that targets a write-protected quadrant raises `reject_o`, so the front end can NACK the word address and the data bytes. Nothing from that transfer is programmed. A Start or a bus timeout before Stop arrives as `abort_i` and discards the row. A Stop that follows a header with no data bytes programs nothing. This is the address-setting half of a random read.

Top module: `pgw_engine`

## Requirements
- R1: After reset `busy_o`, `reject_o` and `arr_we_o` are low.
- R2: A header sets the start column to address bits [3:0]. Each accepted byte is stored at the current column, and the column then advances by one. Bits [7:4] of the address and the half-select stay fixed, and the array address is {half, address[7:4], column}.
- R3: The column wraps from 15 to 0. When more than 16 bytes are loaded, each later byte replaces the earlier byte at the same column, and the last byte written to a column is the one committed.
- R4: The first byte may start at any column. Only columns loaded since the header are written to the array, and all other array locations keep their contents.
- R5: `busy_o` rises in the cycle after a Stop that follows at least one loaded byte, never otherwise. No array write occurs while `busy_o` is low.
- R6: `busy_o` stays high for exactly PROG_CYCLES clock cycles, independent of how many bytes were loaded.
- R7: While `busy_o` is high, header, byte, Stop and abort inputs have no effect: no second window starts and nothing from them reaches the array.
- R8: The quadrant index is {half, address[7]}. If bit q of `prot_i` is set at the header, `reject_o` is high from the next cycle until Stop or abort, and that transfer programs nothing.
- R9: `abort_i` before Stop discards all loaded bytes: the following Stop starts no programming.
- R10: A Stop after a header with no data bytes starts no programming.
- R11: A new header clears the loaded-column record, so bytes loaded under an earlier header that did not reach Stop are not committed.
- R12: Array writes occur within the first 16 cycles of the busy window, one column per cycle in ascending column order, with at most 16 writes per window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hdr_i | input | 1 | Write header strobe (word address received) |
| hdr_addr_i | input | WORD_AW | Word address within the selected half |
| half_i | input | 1 | Half-select: 0 lower, 1 upper |
| prot_i | input | 4 | Per-quadrant write-protect mask |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop condition seen |
| abort_i | input | 1 | Start or bus timeout before Stop |
| busy_o | output | 1 | Programming window active |
| reject_o | output | 1 | Current transfer targets a protected quadrant |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | WORD_AW+1 | Array byte address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
Every strobe is registered once: `reject_o` follows a header by one cycle, and `busy_o` follows the accepting Stop by one cycle. The array write for busy-cycle i, where i is below 16, appears in that same cycle when column i is loaded. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which is one register stage later. It then counts falling edges while `busy_o` is high, so the window length is compared exactly against PROG_CYCLES. Array contents are checked in the bench's own array model after the window closes, and the write addresses logged during the window are checked for order and count.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_REJECT = 2'd2
  } hdr_st_e;
endpackage

// File: rtl/pgw_row_buf.sv
module pgw_row_buf #(
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic [COL_W-1:0]      wr_col_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [COL_W-1:0]      rd_col_i,
  output logic [PAGE_BYTES-1:0] vld_o,
  output logic [DATA_W-1:0]     rd_data_o
);
  logic [DATA_W-1:0] data_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
    logic hit;
    assign hit = wr_i && (wr_col_i == COL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g]  <= 1'b0;
        data_q[g] <= '0;
      end else if (clr_i) begin
        vld_o[g]  <= 1'b0;
      end else if (hit) begin
        vld_o[g]  <= 1'b1;
        data_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = data_q[rd_col_i];
endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
  parameter int unsigned PROG_CYCLES = 250000,
  parameter int unsigned CNT_W       = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else if (!busy_o) begin
      if (start_i) busy_o <= 1'b1;
      cnt_o <= '0;
    end else if (cnt_o == LAST) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pgw_commit.sv
module pgw_commit #(
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned WORD_AW    = 8,
  parameter int unsigned CNT_W      = 18,
  localparam int unsigned COL_W     = $clog2(PAGE_BYTES),
  localparam int unsigned ROW_W     = WORD_AW - COL_W,
  localparam int unsigned ARR_AW    = WORD_AW + 1
) (
  input  logic                  busy_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic [PAGE_BYTES-1:0] vld_i,
  input  logic [DATA_W-1:0]     rd_data_i,
  input  logic                  half_i,
  input  logic [ROW_W-1:0]      row_i,
  output logic [COL_W-1:0]      rd_col_o,
  output logic                  we_o,
  output logic [ARR_AW-1:0]     addr_o,
  output logic [DATA_W-1:0]     data_o
);
  logic in_win;

  // one column per cycle in the leading part of the window
  assign in_win   = cnt_i < CNT_W'(PAGE_BYTES);
  assign rd_col_o = cnt_i[COL_W-1:0];
  assign we_o     = busy_i && in_win && vld_i[rd_col_o];
  assign addr_o   = {half_i, row_i, rd_col_o};
  assign data_o   = rd_data_i;
endmodule

// File: rtl/pgw_engine.sv
module pgw_engine #(
  parameter int unsigned PAGE_BYTES  = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WORD_AW     = 8,
  parameter int unsigned PROG_CYCLES = 250000,
  localparam int unsigned COL_W      = $clog2(PAGE_BYTES),
  localparam int unsigned ROW_W      = WORD_AW - COL_W,
  localparam int unsigned ARR_AW     = WORD_AW + 1,
  localparam int unsigned TW_RAW     = $clog2(PROG_CYCLES + 1),
  localparam int unsigned CNT_W      = (TW_RAW > COL_W) ? TW_RAW : COL_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hdr_i,
  input  logic [WORD_AW-1:0] hdr_addr_i,
  input  logic               half_i,
  input  logic [3:0]         prot_i,
  input  logic               byte_vld_i,
  input  logic [DATA_W-1:0]  byte_i,
  input  logic               stop_i,
  input  logic               abort_i,
  output logic               busy_o,
  output logic               reject_o,
  output logic               arr_we_o,
  output logic [ARR_AW-1:0]  arr_addr_o,
  output logic [DATA_W-1:0]  arr_data_o
);
  import pgw_pkg::*;

  hdr_st_e               st_q, st_d;
  logic                  half_q;
  logic [ROW_W-1:0]      row_q;
  logic [COL_W-1:0]      col_q;
  logic [1:0]            quad_w;
  logic                  live, take_abort, take_hdr, take_byte, take_stop, prog_go;
  logic [PAGE_BYTES-1:0] vld;
  logic [DATA_W-1:0]     rd_data;
  logic [COL_W-1:0]      rd_col;
  logic [CNT_W-1:0]      tmr_cnt;

  assign quad_w     = {half_i, hdr_addr_i[WORD_AW-1]};
  assign live       = !busy_o;
  assign take_abort = live && abort_i;
  assign take_hdr   = live && hdr_i && !abort_i;
  assign take_stop  = live && stop_i && !abort_i && !hdr_i;
  assign take_byte  = live && byte_vld_i && !abort_i && !hdr_i && !stop_i
                      && (st_q == ST_LOAD);
  assign prog_go    = take_stop && (st_q == ST_LOAD) && (|vld);

  always_comb begin
    st_d = st_q;
    if (take_abort || take_stop) st_d = ST_IDLE;
    else if (take_hdr)           st_d = prot_i[quad_w] ? ST_REJECT : ST_LOAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      half_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      st_q <= st_d;
      if (take_hdr) begin
        half_q <= half_i;
        row_q  <= hdr_addr_i[WORD_AW-1:COL_W];
        col_q  <= hdr_addr_i[COL_W-1:0];
      end else if (take_byte) begin
        col_q  <= col_q + 1'b1;  // wraps inside the row
      end
    end
  end

  assign reject_o = (st_q == ST_REJECT);

  pgw_row_buf #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (DATA_W)
  ) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (take_abort || take_hdr),
    .wr_i     (take_byte),
    .wr_col_i (col_q),
    .wr_data_i(byte_i),
    .rd_col_i (rd_col),
    .vld_o    (vld),
    .rd_data_o(rd_data)
  );

  pgw_prog_timer #(
    .PROG_CYCLES(PROG_CYCLES),
    .CNT_W      (CNT_W)
  ) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(prog_go),
    .busy_o (busy_o),
    .cnt_o  (tmr_cnt)
  );

  pgw_commit #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (DATA_W),
    .WORD_AW   (WORD_AW),
    .CNT_W     (CNT_W)
  ) u_cmt (
    .busy_i   (busy_o),
    .cnt_i    (tmr_cnt),
    .vld_i    (vld),
    .rd_data_i(rd_data),
    .half_i   (half_q),
    .row_i    (row_q),
    .rd_col_o (rd_col),
    .we_o     (arr_we_o),
    .addr_o   (arr_addr_o),
    .data_o   (arr_data_o)
  );
endmodule

// File: rtl/pgw_engine_chk.sv
module pgw_engine_chk #(
  parameter int unsigned PAGE_BYTES  = 16,
  parameter int unsigned PROG_CYCLES = 250000,
  parameter int unsigned ARR_AW      = 9,
  localparam int unsigned COL_W      = $clog2(PAGE_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              busy_o,
  input logic              reject_o,
  input logic              arr_we_o,
  input logic [ARR_AW-1:0] arr_addr_o
);
  int unsigned bcnt, wcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt <= 0;
      wcnt <= 0;
    end else begin
      bcnt <= busy_o ? bcnt + 1 : 0;
      wcnt <= busy_o ? wcnt + (arr_we_o ? 1 : 0) : 0;
    end
  end

  p_we_in_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  p_busy_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(busy_o)) |-> (bcnt == PROG_CYCLES));

  p_no_prog_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reject_o && stop_i && !busy_o) |=> !busy_o);

  p_row_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && $past(arr_we_o)) |->
      (arr_addr_o[ARR_AW-1:COL_W] == $past(arr_addr_o[ARR_AW-1:COL_W])));

  p_we_limit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt <= PAGE_BYTES);
endmodule

bind pgw_engine pgw_engine_chk #(
  .PAGE_BYTES (PAGE_BYTES),
  .PROG_CYCLES(PROG_CYCLES),
  .ARR_AW     (ARR_AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stop_i    (stop_i),
  .busy_o    (busy_o),
  .reject_o  (reject_o),
  .arr_we_o  (arr_we_o),
  .arr_addr_o(arr_addr_o)
);

// File: tb/sim_pgw_engine.sv
module sim_pgw_engine;
  localparam int PROG = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hdr_i = 0, half_i = 0, byte_vld_i = 0, stop_i = 0, abort_i = 0;
  logic [7:0] hdr_addr_i = 0, byte_i = 0;
  logic [3:0] prot_i = 0;
  logic       busy_o, reject_o, arr_we_o;
  logic [8:0] arr_addr_o;
  logic [7:0] arr_data_o;

  int checks = 0, failures = 0;
  logic [7:0] mem [512];
  logic [8:0] wlog [64];
  int wn = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pgw_engine #(.PROG_CYCLES(PROG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hdr_i(hdr_i), .hdr_addr_i(hdr_addr_i),
    .half_i(half_i), .prot_i(prot_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .stop_i(stop_i), .abort_i(abort_i), .busy_o(busy_o), .reject_o(reject_o),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o)
  );

  // bench-side array model fed by the write port
  always @(posedge clk) begin
    if (arr_we_o) begin
      mem[arr_addr_o] <= arr_data_o;
      if (wn < 64) wlog[wn] <= arr_addr_o;
      wn <= wn + 1;
    end
  end

  function automatic logic [7:0] init_val(int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_hdr(logic h, logic [7:0] a, logic [3:0] p);
    hdr_i = 1; half_i = h; hdr_addr_i = a; prot_i = p;
    @(negedge clk); hdr_i = 0;
  endtask

  task automatic send_byte(logic [7:0] d);
    byte_vld_i = 1; byte_i = d;
    @(negedge clk); byte_vld_i = 0;
  endtask

  task automatic send_stop();
    stop_i = 1; @(negedge clk); stop_i = 0;
  endtask

  task automatic send_abort();
    abort_i = 1; @(negedge clk); abort_i = 0;
  endtask

  // after send_stop: returns busy cycle count, ends with busy low
  task automatic wait_busy(output int n);
    n = 0;
    while (busy_o && n < PROG + 10) begin n++; @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 reject", reject_o, 0);
    chk("R1 we", arr_we_o, 0);
  endtask

  task automatic t_byte_write();
    int n;
    send_hdr(0, 8'h35, 4'h0);
    send_byte(8'hA5);
    chk("R5 no busy before stop", busy_o, 0);
    chk("R5 no write before stop", wn, 0);
    send_stop();
    chk("R5 busy after stop", busy_o, 1);
    wait_busy(n);
    chk("R6 window single byte", n, PROG);
    chk("R2 byte stored", mem[9'h035], 8'hA5);
    chk("R4 neighbour kept", mem[9'h036], init_val(9'h036));
    chk("R12 one write", wn, 1);
  endtask

  task automatic t_partial();
    int n;
    wn = 0;
    send_hdr(1, 8'h9C, 4'b0100);
    chk("R8 no reject unprotected", reject_o, 0);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    send_stop();
    wait_busy(n);
    chk("R6 window partial", n, PROG);
    chk("R2 col C", mem[9'h19C], 8'h11);
    chk("R2 col D", mem[9'h19D], 8'h22);
    chk("R2 col E", mem[9'h19E], 8'h33);
    chk("R4 col B kept", mem[9'h19B], init_val(9'h19B));
    chk("R4 col F kept", mem[9'h19F], init_val(9'h19F));
    chk("R4 lower half kept", mem[9'h09C], init_val(9'h09C));
  endtask

  task automatic t_wrap();
    int n;
    wn = 0;
    send_hdr(0, 8'h4E, 4'h0);
    for (int i = 0; i < 18; i++) send_byte(8'(8'hC0 + i));
    send_stop();
    wait_busy(n);
    chk("R6 window full", n, PROG);
    chk("R3 col E overwritten", mem[9'h04E], 8'hD0);
    chk("R3 col F overwritten", mem[9'h04F], 8'hD1);
    for (int c = 0; c < 14; c++)
      chk("R3 wrapped cols", mem[9'h040 + c], 8'hC2 + c);
    chk("R2 next row kept", mem[9'h050], init_val(9'h050));
    chk("R12 write count", wn, 16);
    for (int i = 0; i < 16; i++)
      chk("R12 ascending order", wlog[i], 9'h040 + i);
  endtask

  task automatic t_protect();
    send_hdr(1, 8'h10, 4'b0100);
    chk("R8 reject raised", reject_o, 1);
    send_byte(8'hEE);
    chk("R8 reject held", reject_o, 1);
    send_stop();
    chk("R8 no busy", busy_o, 0);
    chk("R8 reject cleared", reject_o, 0);
    repeat (20) @(negedge clk);
    chk("R8 mem kept", mem[9'h110], init_val(9'h110));
  endtask

  task automatic t_abort();
    send_hdr(0, 8'hA0, 4'h0);
    send_byte(8'h77); send_byte(8'h78);
    send_abort();
    send_stop();
    chk("R9 no busy", busy_o, 0);
    repeat (20) @(negedge clk);
    chk("R9 mem kept", mem[9'h0A0], init_val(9'h0A0));
  endtask

  task automatic t_empty();
    send_hdr(0, 8'hB3, 4'h0);
    send_stop();
    chk("R10 no busy", busy_o, 0);
  endtask

  task automatic t_rehdr();
    int n;
    send_hdr(0, 8'h20, 4'h0);
    send_byte(8'h5C);
    send_hdr(0, 8'h61, 4'h0);
    send_byte(8'h3D);
    send_stop();
    wait_busy(n);
    chk("R11 new row written", mem[9'h061], 8'h3D);
    chk("R11 old byte dropped", mem[9'h020], init_val(9'h020));
    chk("R11 old col in new row", mem[9'h060], init_val(9'h060));
  endtask

  task automatic t_busy_ignore();
    int n, m;
    send_hdr(0, 8'hC5, 4'h0);
    send_byte(8'h01);
    send_stop();
    send_hdr(0, 8'h70, 4'hF);
    chk("R7 reject not raised", reject_o, 0);
    send_byte(8'h99);
    send_stop();
    send_abort();
    wait_busy(n);
    chk("R7 window unchanged", n, PROG - 4);
    repeat (5) @(negedge clk);
    m = busy_o;
    chk("R7 no second window", m, 0);
    chk("R7 ignored byte", mem[9'h070], init_val(9'h070));
    chk("R7 first write done", mem[9'h0C5], 8'h01);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_partial();
    t_wrap();
    t_protect();
    t_abort();
    t_empty();
    t_rehdr();
    t_busy_ignore();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule